// File: doc/BRIEF.md
# Edge-Triggered Pin Interrupt Port

This block watches an eight-bit group of asynchronous input pins and turns chosen pin transitions into one interrupt request. Each pin is first brought into the clock domain through a short flop chain. Each pin then has its own polarity choice: it reacts either to a rising or to a falling change. A qualifying change latches a per-pin pending bit. The single request line is high while any pending bit is also individually unmasked. Because every pin drives the same request line, all pins share one interrupt vector, and the service routine reads the pending bits to see which pins need attention.

Software reaches three control registers and a read-only view of the synchronised pin levels through a small register bus. Reads are combinational, and writes take effect at the clock edge. A pending bit is cleared by writing 0 to it. Writing 1 to a pending bit leaves it as it is. A steady pin level never raises a pending bit, whatever that level is.

Top module: `gpio_edge_irq_port`

## Requirements
- R1: After synchronous reset the polarity, mask and pending registers read 0 and `irq` is 0. A pin that is already high when reset is released does not set a pending bit.
- R2: When the polarity bit of a pin is 0, a low-to-high change on that pin sets its pending bit. The bit reads 1 after the third rising clock edge that follows the change, and reads 0 after only two edges.
- R3: When the polarity bit of a pin is 1, a high-to-low change on that pin sets its pending bit.
- R4: A change in the opposite direction to the selected polarity does not set a pending bit. A steady level, high or low, does not set one either.
- R5: `irq` equals the OR over all pins of (pending AND mask). A mask bit of 0 blocks that pin from the request.
- R6: A pending bit latches even while its mask bit is 0. Writing the mask bit to 1 later raises `irq` right after that write.
- R7: Writing 0 to a bit of the pending register clears that bit. Writing 1 leaves the bit unchanged.
- R8: If a qualifying change sets a pending bit in the same clock cycle that software writes 0 to that bit, the bit ends up 1.
- R9: Writing the polarity register while the pin levels stay steady sets no pending bit.
- R10: Register map on `bus_addr`: 0 is the synchronised pin levels (read-only, writes have no effect), 1 is polarity, 2 is mask, 3 is pending. Bit i of each register belongs to pin i.
- R11: Pins are independent: a change on one pin sets only that pin's pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_in | input | 8 | Asynchronous pin levels |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a software clear that lands in exactly the same cycle as a pending-bit set. The synchroniser and edge stage hide that cycle behind three clock edges. The bench changes a pin on a falling clock edge and counts two rising edges. It then presents the clear write so that the write commits on the third edge, which is the edge where the set happens. In the same run it also checks that the bit is still clear one edge earlier, which pins down the latency.

// File: rtl/gpio_irq_pkg.sv
// Package: shared constants and the register address map of the pin
// interrupt port. Assumes a four-entry register space.
package gpio_irq_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_LEVEL = 2'd0,
        ADDR_EDGE  = 2'd1,
        ADDR_MASK  = 2'd2,
        ADDR_PEND  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/gpio_pin_sync.sv
// Module: per-bit flop chain that moves asynchronous pin levels into the
// clock domain. Assumes pins are slow compared with clk; STAGES >= 2.
module gpio_pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_async,
    output logic [W-1:0] pin_sync
);
    logic [STAGES-1:0][W-1:0] chain;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // capture the raw pins
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= pin_async;
                end
            end else begin : g_next
                // shift through the remaining stages
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign pin_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_edge_detect.sv
// Module: compares the synchronised level with its value from the previous
// cycle and flags the polarity chosen per bit. It stays disarmed until the
// sync chain and the history register hold real pin values, so levels that
// are present at reset release produce no event. Because it compares level
// history, changing the polarity alone never makes an event.
module gpio_edge_detect #(
    parameter int W          = 8,
    parameter int ARM_CYCLES = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] edge_sel,
    output logic [W-1:0] evt
);
    localparam int CNT_W = $clog2(ARM_CYCLES + 1);
    localparam logic [CNT_W-1:0] ARM_LAST = CNT_W'(ARM_CYCLES);

    logic [W-1:0]     prev;
    logic [CNT_W-1:0] arm_cnt;
    logic             armed;

    // hold last cycle's level for comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= level;
    end

    // count cycles after reset until history is valid
    always_ff @(posedge clk) begin
        if (!rst_n)         arm_cnt <= '0;
        else if (!armed)    arm_cnt <= arm_cnt + 1'b1;
    end

    assign armed = (arm_cnt == ARM_LAST);

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            assign evt[i] = armed & (edge_sel[i] ? (prev[i] & ~level[i])
                                                : (~prev[i] & level[i]));
        end
    endgenerate

    // R1
    no_event_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (evt == '0));
    // R4
    no_event_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == prev) |-> (evt == '0));
endmodule

// File: rtl/gpio_irq_regs.sv
// Module: polarity, mask and pending registers with the bus decode. A set
// event beats a software clear of the same bit in the same cycle. Assumes
// single-cycle bus writes qualified by sel & wr.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      level,
    input  logic [W-1:0]      set_evt,
    output logic [W-1:0]      edge_sel,
    output logic [W-1:0]      mask,
    output logic [W-1:0]      pend
);
    logic wr_edge, wr_mask, wr_pend;
    logic [W-1:0] keep;

    // decode write strobes
    always_comb begin
        wr_edge = bus_sel & bus_wr & (bus_addr == ADDR_EDGE);
        wr_mask = bus_sel & bus_wr & (bus_addr == ADDR_MASK);
        wr_pend = bus_sel & bus_wr & (bus_addr == ADDR_PEND);
        keep    = wr_pend ? bus_wdata : '1;
    end

    // polarity register
    always_ff @(posedge clk) begin
        if (!rst_n)       edge_sel <= '0;
        else if (wr_edge) edge_sel <= bus_wdata;
    end

    // mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (wr_mask) mask <= bus_wdata;
    end

    // pending register: write-zero clear, set takes priority
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & keep) | set_evt;
    end

    // combinational read mux
    always_comb begin
        case (bus_addr)
            ADDR_LEVEL: bus_rdata = level;
            ADDR_EDGE:  bus_rdata = edge_sel;
            ADDR_MASK:  bus_rdata = mask;
            default:    bus_rdata = pend;
        endcase
    end

    // R2
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_evt) |=> ((pend & $past(set_evt)) == $past(set_evt)));
    // R4
    pend_rise_only_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend) & ~$past(set_evt)) == '0));
    // R7
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend |=> ((pend & ~$past(bus_wdata) & ~$past(set_evt)) == '0));
endmodule

// File: rtl/gpio_edge_irq_port.sv
// Module: top of the edge-triggered pin interrupt port. Chains the
// synchroniser, edge detector and register file, and ORs the unmasked
// pending bits into one request. Assumes one clock and synchronous reset.
module gpio_edge_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      pin_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              irq
);
    localparam int ARM_CYCLES = SYNC_STAGES + 1;

    logic [W-1:0] level, evt, edge_sel, mask, pend;

    gpio_pin_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_in), .pin_sync(level)
    );

    gpio_edge_detect #(.W(W), .ARM_CYCLES(ARM_CYCLES)) u_edge (
        .clk(clk), .rst_n(rst_n), .level(level), .edge_sel(edge_sel), .evt(evt)
    );

    gpio_irq_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .level(level), .set_evt(evt),
        .edge_sel(edge_sel), .mask(mask), .pend(pend)
    );

    // combine unmasked pending bits
    always_comb irq = |(pend & mask);

    // R6
    irq_after_unmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(pend) & mask & pend)) |-> irq);
    // R5
    irq_masked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
endmodule

// File: tb/gpio_edge_irq_port_test.sv
module gpio_edge_irq_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_in = 8'h00;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_edge_irq_port uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        pin_in = 8'h3C;                       // some pins high through reset
        wait_edges(3);
        rst_n = 1;
        wait_edges(6);
        // R1 reset state and no flag from levels present at release
        rd(2'd1, v); chk("R1 edge", v, 8'h00);
        rd(2'd2, v); chk("R1 mask", v, 8'h00);
        rd(2'd3, v); chk("R1 pend", v, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        // R10 level view and write to it ignored
        rd(2'd0, v); chk("R10 level", v, 8'h3C);
        wr(2'd0, 8'hFF);
        rd(2'd0, v); chk("R10 level ro", v, 8'h3C);
        rd(2'd1, v); chk("R10 edge untouched", v, 8'h00);
        rd(2'd2, v); chk("R10 mask untouched", v, 8'h00);
        rd(2'd3, v); chk("R10 pend untouched", v, 8'h00);

        // sweep every pin and both polarities
        for (int pol = 0; pol < 2; pol++) begin
            logic [7:0] idle;
            idle = (pol == 0) ? 8'h00 : 8'hFF;
            wr(2'd1, idle);
            pin_in = idle;
            wait_edges(5);
            wr(2'd3, 8'h00);
            for (int b = 0; b < 8; b++) begin
                logic [7:0] bit_m;
                bit_m = 8'h01 << b;
                wr(2'd2, 8'h00);
                pin_in = idle ^ bit_m;            // active edge
                wait_edges(2);
                rd(2'd3, v); chk("R2 latency two edges", v, 8'h00);
                wait_edges(1);
                rd(2'd3, v);
                chk(pol == 0 ? "R2 rise sets/R11" : "R3 fall sets/R11", v, bit_m);
                // R5 masked off
                chk("R5 masked irq", {7'd0, irq}, 8'h00);
                wr(2'd2, ~bit_m);
                chk("R5 other mask irq", {7'd0, irq}, 8'h00);
                // R6 latched while masked, raises on unmask
                wr(2'd2, bit_m);
                chk("R6 unmask irq", {7'd0, irq}, 8'h01);
                // R7 write 1 keeps, write 0 clears
                wr(2'd3, 8'hFF);
                rd(2'd3, v); chk("R7 write one keeps", v, bit_m);
                wr(2'd3, ~bit_m);
                rd(2'd3, v); chk("R7 write zero clears", v, 8'h00);
                chk("R5 irq low after clear", {7'd0, irq}, 8'h00);
                // R4 opposite edge and steady level
                pin_in = idle;
                wait_edges(6);
                rd(2'd3, v); chk("R4 opposite edge", v, 8'h00);
            end
        end

        // R9 polarity change with steady pins
        pin_in = 8'hA5;
        wait_edges(5);
        wr(2'd3, 8'h00);
        wr(2'd1, 8'h0F);
        wait_edges(4);
        wr(2'd1, 8'hF0);
        wait_edges(4);
        rd(2'd3, v); chk("R9 polarity change", v, 8'h00);

        // R8 set beats clear in the same cycle
        wr(2'd1, 8'h00);
        pin_in = 8'h00;
        wait_edges(5);
        wr(2'd3, 8'h00);
        pin_in = 8'h02;
        wait_edges(4);
        rd(2'd3, v); chk("R11 single pin", v, 8'h02);
        pin_in = 8'h42;                           // pin 6 rises at a negedge
        @(posedge clk); @(posedge clk); @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 2'd3; bus_wdata = 8'h00;
        @(posedge clk); @(negedge clk);           // set and clear together
        bus_sel = 0; bus_wr = 0;
        rd(2'd3, v); chk("R8 set wins", v, 8'h40);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule